// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the opening Start condition of an I2C transfer for a bus master. Software sets a start-enable bit in a small command register. The block then checks that both bus lines are idle high and times two equal baud periods from a 7-bit reload value. In the first period both lines stay released. At its end SDA is pulled low while SCL stays high, which is the Start condition. The second period ends the sequence: the start-enable bit clears by itself, an interrupt flag is raised, and SDA stays held low for the stage that follows.

The bus lines are sampled through a two-stage synchronizer. A line found low when the sequence begins, or SCL found low before SDA has been pulled, aborts the Start and raises a sticky bus-collision flag. While the start-enable bit is set, the block protects its transmit buffer and command bits. A buffer write is dropped and raises a sticky write-collision flag. A command write is dropped without any flag.

Top module: `i2c_start_gen`

## Requirements
- R1: The sequence begins at the first clock edge where the start-enable bit (`cmd_o[0]`) is set, and only if both synchronized lines read high. The counter is then loaded with `baud_reload_i` (value N), and SDA stays released for N+1 cycles. Counted from the edge that stores the command write, SDA is pulled low at edge N+2.
- R2: At the end of the first period, if both lines still read high, `sda_drive_low_o` and `start_det_o` rise together. `scl_drive_low_o` stays 0 at all times.
- R3: The second period lasts N+1 cycles. At its end `start_en_o` falls and SDA stays pulled low until reset. In this held state a command write stores bits 4..1 but not the start-enable bit.
- R4: `irq_o` (flag bit 0) is set in the same cycle that `start_en_o` falls at completion.
- R5: If either synchronized line reads low when the sequence would begin, `bcol_o` (flag bit 1) is set and the start-enable bit clears. SDA stays released and the block is idle, so a later start can run.
- R6: During the first period, SCL reading low aborts the Start, and so does SDA reading low at the expiry edge. Either case sets `bcol_o` and clears the start-enable bit, and `start_det_o` stays 0.
- R7: A buffer write in a cycle where the start-enable bit is set leaves `buf_o` unchanged and sets `wcol_o` (flag bit 2). When the bit is clear, the write stores `buf_wdata_i`.
- R8: A command write in a cycle where the start-enable bit is set has no effect on `cmd_o`.
- R9: The three flags are sticky. A flag write with bit k at 0 clears flag k, and bit k at 1 leaves it unchanged. A set in the same cycle wins over a clear.
- R10: A reload value of 0 gives periods of one cycle each: SDA is pulled low at edge 2 and `start_en_o` falls one edge later.
- R11: Line inputs reach the sequencer two clock edges after they are sampled. A one-cycle SCL low pulse driven together with the command write therefore aborts the sequence in the first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_reload_i | input | 7 | Baud counter reload value N |
| cmd_wr_i | input | 1 | Command register write strobe |
| cmd_wdata_i | input | 5 | Command write data, bit 0 is start-enable |
| buf_wr_i | input | 1 | Transmit buffer write strobe |
| buf_wdata_i | input | 8 | Transmit buffer write data |
| flag_wr_i | input | 1 | Flag register write strobe |
| flag_wdata_i | input | 3 | Flag write data, a 0 bit clears that flag |
| sda_i | input | 1 | Sampled SDA line level |
| scl_i | input | 1 | Sampled SCL line level |
| sda_drive_low_o | output | 1 | Pull SDA low when 1, release when 0 |
| scl_drive_low_o | output | 1 | Pull SCL low when 1, release when 0 |
| start_en_o | output | 1 | Start-enable bit, cleared by hardware |
| cmd_o | output | 5 | Command register contents |
| buf_o | output | 8 | Transmit buffer contents |
| start_det_o | output | 1 | Start condition has been issued |
| irq_o | output | 1 | Sequence-complete interrupt flag |
| bcol_o | output | 1 | Bus-collision flag |
| wcol_o | output | 1 | Write-collision flag |

## Verification
Two collisions are provoked on purpose. First, a buffer write is timed onto the exact edge where hardware clears the start-enable bit. The write is still seen as busy, so it must be dropped with `wcol_o` set, and only the next write lands. Second, a flag-clear write is placed in the same cycle as a dropped buffer write, and `wcol_o` must stay set. A behavioural model, which includes its own line-synchronizer delay, judges every clock. Directed cycle counts pin down both periods.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,   // first period, lines released
    ST_TAIL,   // second period, SDA low
    ST_HOLD    // done, SDA held low
  } start_state_e;

  localparam int unsigned NUM_FLAGS = 3;
  localparam int unsigned FLAG_IRQ  = 0;
  localparam int unsigned FLAG_BCOL = 1;
  localparam int unsigned FLAG_WCOL = 2;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= {WIDTH{RST_VAL}};
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/i2c_baud_cnt.sv
module i2c_baud_cnt #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= reload_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // period = reload + 1 cycles
  assign expire_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/i2c_start_fsm.sv
module i2c_start_fsm
  import i2c_start_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sda_s_i,
  input  logic scl_s_i,
  input  logic expire_i,
  output logic load_o,
  output logic run_o,
  output logic sda_low_o,
  output logic hold_o,
  output logic det_set_o,
  output logic irq_set_o,
  output logic bcol_set_o,
  output logic en_clr_o
);
  start_state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    det_set_o  = 1'b0;
    irq_set_o  = 1'b0;
    bcol_set_o = 1'b0;
    en_clr_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (en_i) begin
          if (sda_s_i && scl_s_i) begin
            load_o  = 1'b1;
            state_d = ST_LEAD;
          end else begin
            bcol_set_o = 1'b1;
            en_clr_o   = 1'b1;
          end
        end
      end
      ST_LEAD: begin
        // SCL low before SDA is pulled takes priority over expiry
        if (!scl_s_i) begin
          bcol_set_o = 1'b1;
          en_clr_o   = 1'b1;
          state_d    = ST_IDLE;
        end else if (expire_i) begin
          if (sda_s_i) begin
            load_o    = 1'b1;
            det_set_o = 1'b1;
            state_d   = ST_TAIL;
          end else begin
            bcol_set_o = 1'b1;
            en_clr_o   = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      ST_TAIL: begin
        if (expire_i) begin
          en_clr_o  = 1'b1;
          irq_set_o = 1'b1;
          state_d   = ST_HOLD;
        end
      end
      default: ;
    endcase
  end

  assign run_o     = (state_q == ST_LEAD) || (state_q == ST_TAIL);
  assign sda_low_o = (state_q == ST_TAIL) || (state_q == ST_HOLD);
  assign hold_o    = (state_q == ST_HOLD);
endmodule

// File: rtl/i2c_start_regs.sv
module i2c_start_regs
  import i2c_start_pkg::*;
#(
  parameter int unsigned CMD_W  = 5,
  parameter int unsigned DATA_W = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_wr_i,
  input  logic [CMD_W-1:0]     cmd_wdata_i,
  input  logic                 buf_wr_i,
  input  logic [DATA_W-1:0]    buf_wdata_i,
  input  logic                 flag_wr_i,
  input  logic [NUM_FLAGS-1:0] flag_wdata_i,
  input  logic                 en_clr_i,
  input  logic                 hold_i,
  input  logic                 det_set_i,
  input  logic                 irq_set_i,
  input  logic                 bcol_set_i,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [DATA_W-1:0]    buf_o,
  output logic                 det_o,
  output logic [NUM_FLAGS-1:0] flags_o
);
  logic [CMD_W-1:0]     cmd_q;
  logic [DATA_W-1:0]    buf_q;
  logic                 det_q;
  logic [NUM_FLAGS-1:0] flag_q;
  logic [NUM_FLAGS-1:0] flag_set;
  logic                 busy;

  assign busy = cmd_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cmd_q    <= '0;
    else if (en_clr_i)             cmd_q[0] <= 1'b0;
    else if (cmd_wr_i && !busy)    cmd_q    <= {cmd_wdata_i[CMD_W-1:1], cmd_wdata_i[0] & ~hold_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                buf_q <= '0;
    else if (buf_wr_i && !busy) buf_q <= buf_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        det_q <= 1'b0;
    else if (det_set_i) det_q <= 1'b1;
  end

  assign flag_set[FLAG_IRQ]  = irq_set_i;
  assign flag_set[FLAG_BCOL] = bcol_set_i;
  assign flag_set[FLAG_WCOL] = buf_wr_i & busy;

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[k] <= 1'b0;
      else         flag_q[k] <= flag_set[k] | (flag_q[k] & ~(flag_wr_i & ~flag_wdata_i[k]));
    end
  end

  assign cmd_o   = cmd_q;
  assign buf_o   = buf_q;
  assign det_o   = det_q;
  assign flags_o = flag_q;
endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int unsigned BAUD_W      = 7,
  parameter int unsigned CMD_W       = 5,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [BAUD_W-1:0]    baud_reload_i,
  input  logic                 cmd_wr_i,
  input  logic [CMD_W-1:0]     cmd_wdata_i,
  input  logic                 buf_wr_i,
  input  logic [DATA_W-1:0]    buf_wdata_i,
  input  logic                 flag_wr_i,
  input  logic [NUM_FLAGS-1:0] flag_wdata_i,
  input  logic                 sda_i,
  input  logic                 scl_i,
  output logic                 sda_drive_low_o,
  output logic                 scl_drive_low_o,
  output logic                 start_en_o,
  output logic [CMD_W-1:0]     cmd_o,
  output logic [DATA_W-1:0]    buf_o,
  output logic                 start_det_o,
  output logic                 irq_o,
  output logic                 bcol_o,
  output logic                 wcol_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0]     line_s;
  logic                 load, run, expire, hold;
  logic                 det_set, irq_set, bcol_set, en_clr;
  logic [NUM_FLAGS-1:0] flags;

  i2c_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .q_o    (line_s)
  );

  i2c_baud_cnt #(.CNT_W(BAUD_W)) u_baud (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .run_i    (run),
    .reload_i (baud_reload_i),
    .expire_o (expire)
  );

  i2c_start_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cmd_o[0]),
    .sda_s_i    (line_s[0]),
    .scl_s_i    (line_s[1]),
    .expire_i   (expire),
    .load_o     (load),
    .run_o      (run),
    .sda_low_o  (sda_drive_low_o),
    .hold_o     (hold),
    .det_set_o  (det_set),
    .irq_set_o  (irq_set),
    .bcol_set_o (bcol_set),
    .en_clr_o   (en_clr)
  );

  i2c_start_regs #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (cmd_wr_i),
    .cmd_wdata_i  (cmd_wdata_i),
    .buf_wr_i     (buf_wr_i),
    .buf_wdata_i  (buf_wdata_i),
    .flag_wr_i    (flag_wr_i),
    .flag_wdata_i (flag_wdata_i),
    .en_clr_i     (en_clr),
    .hold_i       (hold),
    .det_set_i    (det_set),
    .irq_set_i    (irq_set),
    .bcol_set_i   (bcol_set),
    .cmd_o        (cmd_o),
    .buf_o        (buf_o),
    .det_o        (start_det_o),
    .flags_o      (flags)
  );

  // Start phase never pulls SCL
  assign scl_drive_low_o = 1'b0;
  assign start_en_o      = cmd_o[0];
  assign irq_o           = flags[FLAG_IRQ];
  assign bcol_o          = flags[FLAG_BCOL];
  assign wcol_o          = flags[FLAG_WCOL];
endmodule

// File: rtl/i2c_start_gen_chk.sv
module i2c_start_gen_chk #(
  parameter int unsigned CMD_W  = 5,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_wr_i,
  input logic              buf_wr_i,
  input logic              sda_drive_low_o,
  input logic              start_en_o,
  input logic [CMD_W-1:0]  cmd_o,
  input logic [DATA_W-1:0] buf_o,
  input logic              start_det_o,
  input logic              irq_o,
  input logic              bcol_o,
  input logic              wcol_o
);
  // R1
  sda_pull_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_low_o) |-> $past(start_en_o));

  // R2
  det_with_sda_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_drive_low_o) |-> $rose(start_det_o));

  // R3
  sda_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(sda_drive_low_o));

  // R4
  irq_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($fell(start_en_o) && sda_drive_low_o));

  // R6
  bcol_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bcol_o) |-> (!start_en_o && !sda_drive_low_o));

  // R7
  buf_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_en_o && buf_wr_i) |=> (wcol_o && $stable(buf_o)));

  // R8
  cmd_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_en_o && cmd_wr_i) |=> $stable(cmd_o[CMD_W-1:1]));
endmodule

bind i2c_start_gen i2c_start_gen_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .cmd_wr_i        (cmd_wr_i),
  .buf_wr_i        (buf_wr_i),
  .sda_drive_low_o (sda_drive_low_o),
  .start_en_o      (start_en_o),
  .cmd_o           (cmd_o),
  .buf_o           (buf_o),
  .start_det_o     (start_det_o),
  .irq_o           (irq_o),
  .bcol_o          (bcol_o),
  .wcol_o          (wcol_o)
);

// File: tb/test_i2c_start_gen.sv
module test_i2c_start_gen;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] reload = 7'd3;
  logic       cmd_wr = 1'b0;
  logic [4:0] cmd_wdata = '0;
  logic       buf_wr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic       flag_wr = 1'b0;
  logic [2:0] flag_wdata = '0;
  logic       sda = 1'b1, scl = 1'b1;

  logic       sda_low, scl_low, start_en, det, irq, bcol, wcol;
  logic [4:0] cmd;
  logic [7:0] bufv;

  int checks = 0, fails = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_start_gen i_i2c_start_gen (
    .clk_i(clk), .rst_ni(rst_ni), .baud_reload_i(reload),
    .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wdata),
    .buf_wr_i(buf_wr), .buf_wdata_i(buf_wdata),
    .flag_wr_i(flag_wr), .flag_wdata_i(flag_wdata),
    .sda_i(sda), .scl_i(scl),
    .sda_drive_low_o(sda_low), .scl_drive_low_o(scl_low),
    .start_en_o(start_en), .cmd_o(cmd), .buf_o(bufv),
    .start_det_o(det), .irq_o(irq), .bcol_o(bcol), .wcol_o(wcol)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int         m_ph;   // 0 idle, 1 first period, 2 second period, 3 held
  int         m_cnt;
  bit [1:0]   m_s1, m_s2;  // {scl, sda}
  bit [4:0]   m_cmd;
  bit [7:0]   m_buf;
  bit         m_det, m_irq, m_bcol, m_wcol;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_cnt = 0; m_s1 = 2'b11; m_s2 = 2'b11;
      m_cmd = '0; m_buf = '0;
      m_det = 0; m_irq = 0; m_bcol = 0; m_wcol = 0;
    end else begin
      bit en, ls_sda, ls_scl, exp_now, clr, s_irq, s_bcol, s_wcol;
      int nph, cnt;
      en = m_cmd[0]; ls_sda = m_s2[0]; ls_scl = m_s2[1];
      nph = m_ph; cnt = m_cnt;
      exp_now = (m_ph == 1 || m_ph == 2) && m_cnt == 0;
      clr = 0; s_irq = 0; s_bcol = 0;
      if ((m_ph == 1 || m_ph == 2) && cnt > 0) cnt = cnt - 1;
      if (m_ph == 0 && en) begin
        if (ls_sda && ls_scl) begin cnt = int'(reload); nph = 1; end
        else begin s_bcol = 1; clr = 1; end
      end else if (m_ph == 1) begin
        if (!ls_scl) begin s_bcol = 1; clr = 1; nph = 0; end
        else if (exp_now) begin
          if (ls_sda) begin cnt = int'(reload); m_det = 1; nph = 2; end
          else begin s_bcol = 1; clr = 1; nph = 0; end
        end
      end else if (m_ph == 2 && exp_now) begin
        clr = 1; s_irq = 1; nph = 3;
      end
      s_wcol = buf_wr && en;
      if (buf_wr && !en) m_buf = buf_wdata;
      if (clr) m_cmd[0] = 1'b0;
      else if (cmd_wr && !en) m_cmd = {cmd_wdata[4:1], cmd_wdata[0] && (m_ph != 3)};
      m_irq  = s_irq  || (m_irq  && !(flag_wr && !flag_wdata[0]));
      m_bcol = s_bcol || (m_bcol && !(flag_wr && !flag_wdata[1]));
      m_wcol = s_wcol || (m_wcol && !(flag_wr && !flag_wdata[2]));
      m_ph = nph; m_cnt = cnt;
      m_s2 = m_s1; m_s1 = {scl, sda};
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      chk(sda_low == (m_ph >= 2), "R2 sda_drive_low", sda_low, m_ph >= 2);
      chk(scl_low == 1'b0, "R2 scl_drive_low", scl_low, 0);
      chk(start_en == m_cmd[0], "R3 start_en", start_en, m_cmd[0]);
      chk(cmd == m_cmd, "R8 cmd", cmd, m_cmd);
      chk(bufv == m_buf, "R7 buf", bufv, m_buf);
      chk(det == m_det, "R2 start_det", det, m_det);
      chk(irq == m_irq, "R4 irq", irq, m_irq);
      chk(bcol == m_bcol, "R6 bcol", bcol, m_bcol);
      chk(wcol == m_wcol, "R9 wcol", wcol, m_wcol);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      chk(0, "watchdog", cyc, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; sda = 1'b1; scl = 1'b1;
    cmd_wr = 0; buf_wr = 0; flag_wr = 0;
    idle(2);
    rst_ni = 1'b1;
    idle(3);
  endtask

  // drives a command write; returns at the negedge after the storing edge
  task automatic wr_cmd(input logic [4:0] d);
    cmd_wr = 1'b1; cmd_wdata = d;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wr_flags(input logic [2:0] d);
    flag_wr = 1'b1; flag_wdata = d;
    @(negedge clk);
    flag_wr = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] d);
    buf_wr = 1'b1; buf_wdata = d;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  // measures both periods after a start write; n = reload
  task automatic timed_start(input int n, input bit poke, input string tag);
    int k;
    wr_cmd(5'b10101);
    k = 0;
    while (!sda_low && k < 400) begin
      if (poke && k == 1) begin
        cmd_wr = 1'b1; cmd_wdata = 5'b01010;
        buf_wr = 1'b1; buf_wdata = 8'hA5;
      end
      @(negedge clk);
      cmd_wr = 1'b0; buf_wr = 1'b0;
      k++;
    end
    chk(k == n + 2, {tag, " first period"}, k, n + 2);
    chk(det == 1'b1, "R2 det at sda pull", det, 1);
    k = 0;
    while (start_en && k < 400) begin @(negedge clk); k++; end
    chk(k == n + 1, {tag, " second period"}, k, n + 1);
    chk(irq == 1'b1, "R4 irq at completion", irq, 1);
    chk(sda_low == 1'b1, "R3 sda held", sda_low, 1);
  endtask

  initial begin
    idle(2);
    rst_ni = 1'b1;
    idle(2);
    chk(sda_low == 0 && start_en == 0 && det == 0, "R1 reset idle", {sda_low, start_en, det}, 0);
    chk({irq, bcol, wcol} == 3'b000, "R9 reset flags", {irq, bcol, wcol}, 0);

    // normal start with guarded writes mid-sequence
    reload = 7'd3;
    timed_start(3, 1'b1, "R1");
    chk(cmd == 5'b10100, "R8 cmd unchanged by busy write", cmd, 5'b10100);
    chk(bufv == 8'h00 && wcol == 1'b1, "R7 busy buffer write dropped", bufv, 0);
    wr_buf(8'h3C);
    idle(1);
    chk(bufv == 8'h3C, "R7 idle buffer write", bufv, 8'h3C);
    wr_cmd(5'b00011);
    idle(1);
    chk(cmd == 5'b00010 && sda_low, "R3 held state masks start-enable", cmd, 5'b00010);
    wr_flags(3'b110);
    idle(1);
    chk(irq == 0 && wcol == 1, "R9 clear irq only", {irq, wcol}, 1);
    wr_flags(3'b000);
    idle(1);
    chk(wcol == 0, "R9 clear wcol", wcol, 0);

    // collision at begin, then recovery
    do_reset();
    sda = 1'b0;
    idle(4);
    wr_cmd(5'b00001);
    idle(3);
    chk(bcol == 1 && start_en == 0 && sda_low == 0, "R5 begin collision", {bcol, start_en, sda_low}, 3'b100);
    sda = 1'b1;
    idle(4);
    timed_start(3, 1'b0, "R5 restart");

    // SCL low during first period
    do_reset();
    reload = 7'd10;
    wr_cmd(5'b00001);
    idle(4);
    scl = 1'b0;
    idle(4);
    chk(bcol == 1 && det == 0 && start_en == 0, "R6 scl low abort", {bcol, det, start_en}, 3'b100);
    scl = 1'b1;
    idle(4);

    // SDA low at first expiry
    do_reset();
    reload = 7'd5;
    wr_cmd(5'b00001);
    idle(2);
    sda = 1'b0;
    idle(8);
    chk(bcol == 1 && det == 0 && sda_low == 0, "R6 sda low at expiry", {bcol, det, sda_low}, 3'b100);
    sda = 1'b1;
    idle(4);

    // zero reload
    do_reset();
    reload = 7'd0;
    timed_start(0, 1'b0, "R10");

    // synchronizer lag: one-cycle scl pulse with the command write
    do_reset();
    reload = 7'd6;
    cmd_wr = 1'b1; cmd_wdata = 5'b00001; scl = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b0; scl = 1'b1;
    idle(3);
    chk(bcol == 1 && det == 0, "R11 delayed scl pulse aborts", bcol, 1);

    // same-cycle: buffer write on the completion edge, and set vs clear
    do_reset();
    reload = 7'd2;
    wr_cmd(5'b00001);
    idle(1);
    buf_wr = 1'b1; buf_wdata = 8'h11; flag_wr = 1'b1; flag_wdata = 3'b000;
    @(negedge clk);
    buf_wr = 1'b0; flag_wr = 1'b0;
    chk(wcol == 1 && bufv == 0, "R9 set beats clear", wcol, 1);
    wr_flags(3'b011);
    idle(1);
    chk(wcol == 0, "R9 wcol cleared", wcol, 0);
    while (!det) @(negedge clk);
    idle(2);
    buf_wr = 1'b1; buf_wdata = 8'h77;
    @(negedge clk);
    buf_wr = 1'b0;
    chk(start_en == 0 && wcol == 1 && bufv == 0, "R7 write on completion edge dropped", bufv, 0);
    wr_buf(8'h78);
    idle(1);
    chk(bufv == 8'h78, "R7 next write lands", bufv, 8'h78);

    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule